// File: doc/BRIEF.md
# EEPROM Access and Burst Controller

This block sits between a host register bus and the byte engine of a serial configuration EEPROM. The host can read or write one EEPROM byte at a time by loading an address, optionally loading a data byte, and setting a request bit. That bit clears itself when the engine acknowledges. The host can also start an autonomous burst. In a burst the controller walks the EEPROM, decodes address/data records and writes each data byte into on-chip memory through a one-cycle write strobe.

The controller remembers the last EEPROM address it touched. A burst that starts before any access since reset begins at EEPROM address 0. Any later burst resumes at the address after the last one used, wrapping at the top of the EEPROM space. A burst memory address is built from a 9-bit base register on top and 15 bits taken from the record's two address bytes. The top bit of the high address byte is dropped.

Register map (word index on `reg_addr`): 0 control/status, 1 EEPROM address, 2 data byte, 3 burst base, 4 burst start. Reads are combinational and have no side effects.

Top module: `ee_burst_ctl`

## Requirements
- R1: After reset the control register reads 0, the burst register reads 0, the data register reads 0, `ee_req` is low and `mem_we` is low.
- R2: Writing control bit 1 while idle starts a single read. `ee_req` rises with `ee_we`=0 and `ee_addr` equal to the address register. On acknowledge, `ee_rdata` is loaded into the data register and control bit 1 reads back 0.
- R3: Writing control bit 0 while idle starts a single write. `ee_we`=1, `ee_addr` is the address register and `ee_wdata` is the data register, which holds only the low byte of the value written. Control bit 0 reads back 0 once the acknowledge is taken.
- R4: Control bit 2 reads 1 while any operation is in progress. While it is 1, writes to the control, address, data, base and burst registers are ignored. This includes a write that arrives in the same cycle as the acknowledge that ends the operation.
- R5: Writing burst register bit 1 while idle starts a burst. That bit reads 1 until the burst ends and then 0.
- R6: A burst started before any single access or burst byte since reset reads EEPROM addresses starting at 0.
- R7: Any other burst starts at the last EEPROM address used plus one, modulo 2^16.
- R8: A burst reads records of three consecutive bytes: low address, high address, data. For each record, one cycle after the data byte is acknowledged, `mem_we` pulses for one cycle with `mem_addr` = {base[8:0], high[6:0], low[7:0]} and `mem_data` = the data byte. Bit 7 of the high byte is ignored.
- R9: A high address byte of 0xFF ends the burst. No data byte is read for that record, no memory write is issued, and the end marker's address becomes the last address used.
- R10: If both control bits 0 and 1 are written as 1 in one write, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ee_req | output | 1 | Byte request to the EEPROM engine, held until acknowledged |
| ee_we | output | 1 | 1 = byte write, 0 = byte read |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | One-cycle completion from the engine |
| ee_rdata | input | 8 | Byte read, valid with `ee_ack` |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_addr | output | 24 | Memory write address |
| mem_data | output | 8 | Memory write data |

## Verification
A host register write can land in the same cycle as the engine acknowledge that ends an operation. While the acknowledge is being taken, the controller still counts as busy, so that write must be lost. The bench watches the engine model and drives a data-register write, and in another run a new read request, exactly in the acknowledge cycle. It then requires that the data register holds the EEPROM byte and that no further EEPROM access is started.

// File: rtl/ee_burst_ctl.sv
`timescale 1ns/1ps
module ee_burst_ctl #(
  parameter int EE_AW  = 16,
  parameter int BASE_W = 9,
  parameter int LOW_W  = 15,
  parameter int RA_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [RA_W-1:0]         reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    ee_req,
  output logic                    ee_we,
  output logic [EE_AW-1:0]        ee_addr,
  output logic [7:0]              ee_wdata,
  input  logic                    ee_ack,
  input  logic [7:0]              ee_rdata,
  output logic                    mem_we,
  output logic [BASE_W+LOW_W-1:0] mem_addr,
  output logic [7:0]              mem_data
);
  localparam int HI_W = LOW_W - 8;
  localparam logic [RA_W-1:0] OFF_CTRL  = 0;
  localparam logic [RA_W-1:0] OFF_ADDR  = 1;
  localparam logic [RA_W-1:0] OFF_DATA  = 2;
  localparam logic [RA_W-1:0] OFF_BASE  = 3;
  localparam logic [RA_W-1:0] OFF_BURST = 4;
  localparam logic [2:0] S_IDLE = 3'd0, S_SGL = 3'd1, S_HI = 3'd2, S_LO = 3'd3, S_DAT = 3'd4;

  logic [2:0]        state;
  logic              sgl_we;
  logic [EE_AW-1:0]  addr_q, ptr, last_q;
  logic              last_ok;
  logic [7:0]        data_q, lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [BASE_W-1:0] base_q;

  logic busy, rd_bit, wr_bit, burst_bit;
  assign busy      = state != S_IDLE;
  assign rd_bit    = state == S_SGL && !sgl_we;
  assign wr_bit    = state == S_SGL &&  sgl_we;
  assign burst_bit = state == S_LO || state == S_HI || state == S_DAT;

  assign ee_req   = busy;
  assign ee_we    = wr_bit;
  assign ee_addr  = (state == S_SGL) ? addr_q : ptr;
  assign ee_wdata = data_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CTRL:  reg_rdata[2:0] = {busy, rd_bit, wr_bit};
      OFF_ADDR:  reg_rdata[EE_AW-1:0] = addr_q;
      OFF_DATA:  reg_rdata[7:0] = data_q;
      OFF_BASE:  reg_rdata[BASE_W-1:0] = base_q;
      OFF_BURST: reg_rdata[1] = burst_bit;
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sgl_we   <= 1'b0;
      addr_q   <= '0;
      ptr      <= '0;
      last_q   <= '0;
      last_ok  <= 1'b0;
      data_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      base_q   <= '0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= 1'b0;
      if (state == S_IDLE) begin
        if (reg_wr) begin
          case (reg_addr)
            OFF_CTRL: if (reg_wdata[1] || reg_wdata[0]) begin
              state  <= S_SGL;
              sgl_we <= !reg_wdata[1];
            end
            OFF_ADDR:  addr_q <= reg_wdata[EE_AW-1:0];
            OFF_DATA:  data_q <= reg_wdata[7:0];
            OFF_BASE:  base_q <= reg_wdata[BASE_W-1:0];
            OFF_BURST: if (reg_wdata[1]) begin
              state <= S_LO;
              ptr   <= last_ok ? last_q + 1'b1 : '0;
            end
            default: ;
          endcase
        end
      end else if (ee_ack) begin
        last_ok <= 1'b1;
        if (state == S_SGL) begin
          state  <= S_IDLE;
          last_q <= addr_q;
          if (!sgl_we) data_q <= ee_rdata;
        end else begin
          last_q <= ptr;
          ptr    <= ptr + 1'b1;
          case (state)
            S_LO: begin
              lo_q  <= ee_rdata;
              state <= S_HI;
            end
            S_HI: begin
              hi_q  <= ee_rdata[HI_W-1:0];
              state <= (ee_rdata == 8'hFF) ? S_IDLE : S_DAT;
            end
            default: begin
              mem_we   <= 1'b1;
              mem_addr <= {base_q, hi_q, lo_q};
              mem_data <= ee_rdata;
              state    <= S_LO;
            end
          endcase
        end
      end
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, reg_wdata};
endmodule

module ee_burst_ctl_chk #(
  parameter int EE_AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ee_req,
  input logic             ee_ack,
  input logic             ee_we,
  input logic [EE_AW-1:0] ee_addr,
  input logic [7:0]       ee_rdata,
  input logic             mem_we,
  input logic             rd_bit,
  input logic             burst_bit,
  input logic [2:0]       st
);
  localparam logic [2:0] ST_HI = 3'd2;

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_ack |=> ee_req && $stable(ee_addr) && $stable(ee_we));
  a_r2_rd_clears_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_bit) |-> $past(ee_ack));
  a_r5_burst_clears_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_bit) |-> $past(ee_ack));
  a_r8_strobe_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(ee_ack));
  a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  a_r9_end_marker_stops: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_HI && ee_ack && ee_rdata == 8'hFF |=> !ee_req && !mem_we);
endmodule

bind ee_burst_ctl ee_burst_ctl_chk #(.EE_AW(EE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ee_req(ee_req), .ee_ack(ee_ack), .ee_we(ee_we),
  .ee_addr(ee_addr), .ee_rdata(ee_rdata), .mem_we(mem_we), .rd_bit(rd_bit),
  .burst_bit(burst_bit), .st(state)
);

// File: tb/tb_ee_burst_ctl.sv
`timescale 1ns/1ps
module tb_ee_burst_ctl;
  localparam int LAT = 4;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ee_req, ee_we, ee_ack = 0;
  logic [15:0] ee_addr;
  logic [7:0] ee_wdata, ee_rdata = 0;
  logic mem_we;
  logic [23:0] mem_addr;
  logic [7:0] mem_data;

  ee_burst_ctl dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, ref_last = -1, cnt = 0;
  bit done = 0;
  bit [7:0] ee_mem [int];
  int exp_ea[$];
  bit exp_we[$];
  int exp_mem[$];

  function automatic int rd(int a);
    return ee_mem.exists(a) ? int'(ee_mem[a]) : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // EEPROM byte model: acknowledge LAT cycles after a request, compare each access
  always @(negedge clk) begin
    if (!rst_n) begin ee_ack = 0; cnt = 0; end
    else if (ee_ack) begin ee_ack = 0; cnt = 0; end
    else if (ee_req) begin
      cnt++;
      if (cnt >= LAT) begin
        if (exp_ea.size() == 0) chk("R4 unexpected eeprom access", int'(ee_addr), -1);
        else begin
          chk("R8 eeprom address order", int'(ee_addr), exp_ea.pop_front());
          chk("R10 eeprom direction", int'(ee_we), int'(exp_we.pop_front()));
        end
        if (ee_we) ee_mem[int'(ee_addr)] = ee_wdata;
        else ee_rdata = 8'(rd(int'(ee_addr)));
        ee_ack = 1;
      end
    end
  end

  // memory write strobe compared on every clock
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_mem.size() == 0) chk("R9 unexpected memory write", int'({mem_addr, mem_data}), -1);
      else chk("R8 memory write", int'({mem_addr, mem_data}), exp_mem.pop_front());
    end
  end

  task automatic reg_write(input int a, input int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input int a, output int d);
    reg_addr = 3'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic wait_idle;
    int v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      reg_read(0, v);
      if (v[2] == 0) return;
    end
  endtask

  task automatic plan_single(input int a, input bit we);
    exp_ea.push_back(a); exp_we.push_back(we);
    ref_last = a;
  endtask

  task automatic plan_burst(input int base);
    int a = (ref_last < 0) ? 0 : ((ref_last + 1) & 16'hFFFF);
    for (int k = 0; k < 100; k++) begin
      int lo = rd(a);
      int hi = rd((a + 1) & 16'hFFFF);
      exp_ea.push_back(a); exp_we.push_back(0);
      exp_ea.push_back((a + 1) & 16'hFFFF); exp_we.push_back(0);
      if (hi == 255) begin ref_last = (a + 1) & 16'hFFFF; return; end
      exp_ea.push_back((a + 2) & 16'hFFFF); exp_we.push_back(0);
      exp_mem.push_back(((((base & 511) << 15) | ((hi & 127) << 8) | lo) << 8) | rd((a + 2) & 16'hFFFF));
      a = (a + 3) & 16'hFFFF;
    end
  endtask

  task automatic do_read(input int a, input string tag);
    reg_write(1, a);
    plan_single(a, 0);
    reg_write(0, 2);
    wait_idle();
  endtask

  task automatic do_burst(input int base, input string tag);
    int v;
    plan_burst(base);
    reg_write(4, 2);
    reg_read(4, v);
    chk({tag, " R5 burst bit set"}, v, 2);
    wait_idle();
    repeat (2) @(negedge clk);
    reg_read(4, v);
    chk({tag, " R5 burst bit cleared"}, v, 0);
    chk({tag, " R8 all records written"}, exp_mem.size(), 0);
    chk({tag, " R6 R7 all addresses visited"}, exp_ea.size(), 0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int v;
    ee_mem[0] = 8'h34; ee_mem[1] = 8'h12; ee_mem[2] = 8'hA5;
    ee_mem[3] = 8'h01; ee_mem[4] = 8'h92; ee_mem[5] = 8'h5A;
    ee_mem[6] = 8'h00; ee_mem[7] = 8'hFF;
    ee_mem['h40] = 8'h3C;
    ee_mem['h51] = 8'hEF; ee_mem['h52] = 8'h7F; ee_mem['h53] = 8'h66;
    ee_mem['h54] = 8'h10; ee_mem['h55] = 8'hFF;
    ee_mem['h56] = 8'h00; ee_mem['h57] = 8'hFF;
    ee_mem['h70] = 8'h21; ee_mem['h60] = 8'h77; ee_mem['h61] = 8'h88;
    ee_mem['hFFFF] = 8'h44;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    reg_read(0, v); chk("R1 control after reset", v, 0);
    reg_read(4, v); chk("R1 burst after reset", v, 0);
    reg_read(2, v); chk("R1 data after reset", v, 0);
    chk("R1 ee_req after reset", int'(ee_req), 0);
    chk("R1 mem_we after reset", int'(mem_we), 0);

    // R6 first burst from 0, R8 high bit ignored
    reg_write(3, 'h1AB);
    do_burst('h1AB, "first");

    // R2 single read with R4 ignored writes while busy
    reg_write(1, 'h40);
    plan_single('h40, 0);
    reg_write(0, 2);
    reg_read(0, v); chk("R4 R2 busy and read bit", v, 6);
    reg_write(1, 'h99);
    reg_write(0, 1);
    wait_idle();
    @(negedge clk);
    reg_read(0, v); chk("R2 read bit cleared", v, 0);
    reg_read(2, v); chk("R2 data loaded", v, 'h3C);
    reg_read(1, v); chk("R4 address write ignored while busy", v, 'h40);

    // R3 single write, only low byte held
    reg_write(1, 'h50);
    reg_write(2, 'h1C7);
    reg_read(2, v); chk("R3 data holds low byte", v, 'hC7);
    plan_single('h50, 1);
    reg_write(0, 1);
    reg_read(0, v); chk("R3 write bit and busy", v, 5);
    chk("R3 ee_wdata", int'(ee_wdata), 'hC7);
    wait_idle();
    @(negedge clk);
    reg_read(0, v); chk("R3 write bit cleared", v, 0);
    chk("R3 eeprom byte stored", rd('h50), 'hC7);

    // R7 continuation after single access, R9 end marker
    reg_write(3, 'h003);
    do_burst('h003, "resume");
    do_burst('h003, "after end marker R9");

    // R10 both bits: read only
    reg_write(1, 'h70);
    reg_write(2, 'h99);
    plan_single('h70, 0);
    reg_write(0, 3);
    wait_idle();
    @(negedge clk);
    reg_read(2, v); chk("R10 read performed", v, 'h21);
    chk("R10 eeprom unchanged", rd('h70), 'h21);

    // R7 wrap from top address
    do_read('hFFFF, "wrap");
    reg_read(2, v); chk("R2 read at top address", v, 'h44);
    reg_write(3, 'h100);
    do_burst('h100, "wrap R7");

    // R4 coincidence: data write in the acknowledge cycle is lost
    reg_write(1, 'h60);
    plan_single('h60, 0);
    reg_write(0, 2);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #1;
      if (ee_ack) break;
    end
    reg_wr = 1; reg_addr = 2; reg_wdata = 'h11;
    @(negedge clk); reg_wr = 0;
    wait_idle();
    reg_read(2, v); chk("R4 data write at ack ignored", v, 'h77);

    // R4 coincidence: request in the acknowledge cycle is lost
    reg_write(1, 'h61);
    plan_single('h61, 0);
    reg_write(0, 2);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #1;
      if (ee_ack) break;
    end
    reg_wr = 1; reg_addr = 0; reg_wdata = 2;
    @(negedge clk); reg_wr = 0;
    repeat (3 * LAT) @(negedge clk);
    chk("R4 request at ack ignored", int'(ee_req), 0);
    chk("R4 no extra access", exp_ea.size(), 0);
    reg_read(2, v); chk("R2 data after coincidence", v, 'h88);

    summary();
  end
endmodule